// File: doc/BRIEF.md
# Audio Serial Master Clock Generator

This block drives the two timing clocks of an audio serial port that runs as clock master. It divides the master clock into a frame clock and a bit clock. The frame clock marks the sample frame, with its high half carrying the left channel. The bit clock runs 64 times per frame. A 3-bit rate code picks how many master-clock cycles make up one frame. Six ratios are offered, from 128 to 768 master cycles per frame, and three of them are not powers of two.

The block also settles two rate-dependent facts for the rest of the converter. The first is whether a requested 64x ADC oversampling rate may actually be used. The second is whether the ADC has been enabled in a ratio that only the DAC path can use. A new rate code never cuts a frame short. It is picked up on the last master-clock cycle of the running frame, and the two flags always describe the ratio that is actually running.

Top module: `aud_master_clkgen`

## Requirements
- R1: The rate code sets the frame length in master-clock cycles: 0 gives 128, 1 gives 192, 2 gives 256, 3 gives 384, 4 gives 512 and 5 gives 768.
- R2: Reset puts the block in the state of the first cycle of a 256-cycle frame, with frame_clk high and bit_clk low. The first frame after reset runs at 256 cycles whatever rate_code holds.
- R3: frame_clk is high for exactly the first half of every frame and low for the second half.
- R4: Each frame has 64 bit slots of D = ratio/64 master cycles. In each slot, bit_clk is low for the first floor(D/2) cycles and high for the rest. Every edge of frame_clk therefore coincides with a falling edge of bit_clk.
- R5: rate_code is sampled only on the last master-clock cycle of a frame, and the new ratio starts with the next frame. A change made at any other time has no effect on the running frame.
- R6: Rate codes 6 and 7 behave exactly like code 2 (256 cycles per frame).
- R7: adc_mode_err is high exactly when adc_en is high and the running ratio is 128 or 192.
- R8: os64_eff is high exactly when os64_req is high and the running ratio is 256 or 384. In all other ratios the effective rate stays 128x (os64_eff low).
- R9: Both flags follow the running ratio rather than the rate_code input. A code written mid-frame does not change them until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_code | input | 3 | Requested frame ratio code |
| adc_en | input | 1 | ADC path enabled |
| os64_req | input | 1 | Request for 64x ADC oversampling (0 means 128x) |
| frame_clk | output | 1 | Frame clock, high for the left channel |
| bit_clk | output | 1 | Bit clock, 64 periods per frame |
| os64_eff | output | 1 | 64x oversampling in effect |
| adc_mode_err | output | 1 | ADC enabled in a ratio restricted to the DAC path |

## Verification
The bench builds the block with its default parameters: 64 bit slots per frame and a 4-bit slot divider. With these values every ratio is reachable, including the uneven 3-cycle slot at 192 and the 12-cycle slot at 768. Rate codes change at arbitrary points in a frame, so the hold-until-boundary rule is exercised at many offsets. The reserved codes are mixed in with the valid ones. The flag inputs toggle freely, which lets the bench see the flags lag a mid-frame rate change.

// File: rtl/aud_clkgen_pkg.sv
package aud_clkgen_pkg;

    typedef enum logic [2:0] {
        RC_128  = 3'd0,
        RC_192  = 3'd1,
        RC_256  = 3'd2,
        RC_384  = 3'd3,
        RC_512  = 3'd4,
        RC_768  = 3'd5,
        RC_RSV6 = 3'd6,
        RC_RSV7 = 3'd7
    } rate_code_e;

    // Frame length after reset and for reserved codes
    localparam int unsigned RST_RATIO = 256;

endpackage

// File: rtl/aud_rate_decode.sv
module aud_rate_decode
    import aud_clkgen_pkg::*;
#(
    parameter int unsigned BITS_PER_FRAME = 64,
    parameter int unsigned DIV_W          = 4
) (
    input  logic [2:0]       code_i,
    output logic [DIV_W-1:0] div_o,
    output logic             dac_only_o,
    output logic             hi_os_ok_o
);

    int unsigned ratio;

    always_comb begin
        dac_only_o = 1'b0;
        hi_os_ok_o = 1'b0;
        unique case (rate_code_e'(code_i))
            RC_128: begin ratio = 128; dac_only_o = 1'b1; end
            RC_192: begin ratio = 192; dac_only_o = 1'b1; end
            RC_384: begin ratio = 384; hi_os_ok_o = 1'b1; end
            RC_512: ratio = 512;
            RC_768: ratio = 768;
            default: begin ratio = RST_RATIO; hi_os_ok_o = 1'b1; end
        endcase
        div_o = DIV_W'(ratio / BITS_PER_FRAME);
    end

endmodule

// File: rtl/aud_frame_div.sv
module aud_frame_div #(
    parameter int unsigned BITS_PER_FRAME = 64,
    parameter int unsigned DIV_W          = 4,
    parameter int unsigned RST_DIV        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] nxt_div_i,
    input  logic             nxt_dac_only_i,
    input  logic             nxt_hi_os_ok_i,
    output logic             frame_clk_o,
    output logic             bit_clk_o,
    output logic             dac_only_o,
    output logic             hi_os_ok_o
);

    localparam int unsigned BIT_W = $clog2(BITS_PER_FRAME);
    localparam int unsigned HALF  = BITS_PER_FRAME / 2;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             dac_only;
        logic             hi_os_ok;
        logic [DIV_W-1:0] cnt;
        logic [BIT_W-1:0] slot;
        logic             fclk;
        logic             bclk;
    } state_t;

    state_t s_d, s_q;
    logic   slot_end, frame_end;

    always_comb begin
        s_d       = s_q;
        slot_end  = (s_q.cnt == s_q.div - DIV_W'(1));
        frame_end = slot_end && (s_q.slot == BIT_W'(BITS_PER_FRAME - 1));
        if (slot_end) begin
            s_d.cnt  = '0;
            s_d.slot = frame_end ? '0 : s_q.slot + BIT_W'(1);
        end else begin
            s_d.cnt  = s_q.cnt + DIV_W'(1);
        end
        if (frame_end) begin
            s_d.div      = nxt_div_i;
            s_d.dac_only = nxt_dac_only_i;
            s_d.hi_os_ok = nxt_hi_os_ok_i;
        end
        s_d.fclk = (s_d.slot < BIT_W'(HALF));
        s_d.bclk = (s_d.cnt >= (s_d.div >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.div      <= DIV_W'(RST_DIV);
            s_q.dac_only <= 1'b0;
            s_q.hi_os_ok <= 1'b1;
            s_q.cnt      <= '0;
            s_q.slot     <= '0;
            s_q.fclk     <= 1'b1;
            s_q.bclk     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign frame_clk_o = s_q.fclk;
    assign bit_clk_o   = s_q.bclk;
    assign dac_only_o  = s_q.dac_only;
    assign hi_os_ok_o  = s_q.hi_os_ok;

    AST_FCLK_ON_BCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.fclk) |-> (!s_q.bclk && $past(s_q.bclk))); // R4

    AST_SLOT_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < s_q.div); // R4

    AST_RATE_HELD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ($stable(s_q.div) && $stable(s_q.dac_only) && $stable(s_q.hi_os_ok))); // R5

    AST_LEFT_AT_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (s_q.fclk && s_q.slot == '0 && s_q.cnt == '0)); // R3

endmodule

// File: rtl/aud_master_clkgen.sv
module aud_master_clkgen
    import aud_clkgen_pkg::*;
#(
    parameter int unsigned BITS_PER_FRAME = 64,
    parameter int unsigned DIV_W          = 4
) (
    input  logic       mclk,
    input  logic       rst_n,
    input  logic [2:0] rate_code,
    input  logic       adc_en,
    input  logic       os64_req,
    output logic       frame_clk,
    output logic       bit_clk,
    output logic       os64_eff,
    output logic       adc_mode_err
);

    localparam int unsigned RST_DIV = RST_RATIO / BITS_PER_FRAME;

    logic [DIV_W-1:0] nxt_div;
    logic             nxt_dac_only, nxt_hi_os_ok;
    logic             act_dac_only, act_hi_os_ok;

    aud_rate_decode #(
        .BITS_PER_FRAME(BITS_PER_FRAME),
        .DIV_W         (DIV_W)
    ) u_dec (
        .code_i     (rate_code),
        .div_o      (nxt_div),
        .dac_only_o (nxt_dac_only),
        .hi_os_ok_o (nxt_hi_os_ok)
    );

    aud_frame_div #(
        .BITS_PER_FRAME(BITS_PER_FRAME),
        .DIV_W         (DIV_W),
        .RST_DIV       (RST_DIV)
    ) u_div (
        .clk            (mclk),
        .rst_n          (rst_n),
        .nxt_div_i      (nxt_div),
        .nxt_dac_only_i (nxt_dac_only),
        .nxt_hi_os_ok_i (nxt_hi_os_ok),
        .frame_clk_o    (frame_clk),
        .bit_clk_o      (bit_clk),
        .dac_only_o     (act_dac_only),
        .hi_os_ok_o     (act_hi_os_ok)
    );

    assign os64_eff     = os64_req & act_hi_os_ok;
    assign adc_mode_err = adc_en & act_dac_only;

    AST_ERR_NOT_WITH_HI_OS: assert property (@(posedge mclk) disable iff (!rst_n)
        !(adc_mode_err && os64_eff)); // R7

endmodule

// File: tb/test_aud_master_clkgen.sv
module test_aud_master_clkgen;

    localparam int CLK_PERIOD = 10;

    logic       mclk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] rate_code = 3'd0;
    logic       adc_en = 1'b1;
    logic       os64_req = 1'b1;
    logic       frame_clk, bit_clk, os64_eff, adc_mode_err;

    int n_vec = 0;
    int n_bad = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    // behavioural model state
    int pos = 0;
    int ratio = 256;

    always #(CLK_PERIOD/2) mclk = ~mclk;

    aud_master_clkgen i_aud_master_clkgen (
        .mclk        (mclk),
        .rst_n       (rst_n),
        .rate_code   (rate_code),
        .adc_en      (adc_en),
        .os64_req    (os64_req),
        .frame_clk   (frame_clk),
        .bit_clk     (bit_clk),
        .os64_eff    (os64_eff),
        .adc_mode_err(adc_mode_err)
    );

    function automatic int ratio_of(input logic [2:0] c);
        case (c)
            3'd0: return 128;
            3'd1: return 192;
            3'd3: return 384;
            3'd4: return 512;
            3'd5: return 768;
            default: return 256; // R6 reserved codes
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
        end
    endtask

    // model advances on each master-clock edge
    always @(posedge mclk) begin
        if (!rst_n) begin
            pos   = 0;
            ratio = 256;
        end else if (pos == ratio - 1) begin
            pos   = 0;
            ratio = ratio_of(rate_code); // R5 sampled at last cycle of frame
        end else begin
            pos++;
        end
    end

    // compare away from the active edge
    always @(negedge mclk) begin
        if (running && rst_n) begin
            int d;
            d = ratio / 64;
            check("R1 R3 R5 R6", "frame_clk", frame_clk, pos < ratio / 2);
            check("R4", "bit_clk", bit_clk, (pos % d) >= (d / 2));
            check("R8 R9", "os64_eff", os64_eff, os64_req && (ratio == 256 || ratio == 384));
            check("R7 R9", "adc_mode_err", adc_mode_err, adc_en && (ratio == 128 || ratio == 192));
        end
    end

    initial begin
        repeat (200000) @(posedge mclk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired, actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] seq [14] = '{3'd0, 3'd1, 3'd3, 3'd6, 3'd5, 3'd4, 3'd2,
                                  3'd7, 3'd1, 3'd5, 3'd0, 3'd3, 3'd4, 3'd2};
        repeat (3) @(posedge mclk);
        @(negedge mclk);
        // R2 reset state
        check("R2", "reset frame_clk", frame_clk, 1'b1);
        check("R2", "reset bit_clk", bit_clk, 1'b0);
        check("R2 R8", "reset os64_eff", os64_eff, 1'b1);
        check("R2 R7", "reset adc_mode_err", adc_mode_err, 1'b0);
        @(posedge mclk);
        #1;
        rst_n   = 1'b1;
        running = 1'b1;
        // R2: code 0 held from reset, first frame must still be 256
        repeat (300) @(posedge mclk);
        foreach (seq[i]) begin
            int len;
            len = 400 + $urandom_range(0, 1300);
            @(posedge mclk);
            #1;
            rate_code = seq[i];
            for (int k = 0; k < len; k++) begin
                @(posedge mclk);
                #1;
                if ((k % 37) == 0) adc_en = 1'($urandom_range(0, 1));
                if ((k % 53) == 0) os64_req = 1'($urandom_range(0, 1));
            end
        end
        repeat (800) @(posedge mclk);
        @(negedge mclk);
        running = 1'b0;
        done    = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule